// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block drives a single PWM output from a timebase counter that runs on the module clock. Software sets an active period and an active compare count. The counter steps through one period after another. Within each period the output sits at one level while the counter is below the compare count and at the other level for the rest of the period. A polarity bit picks which level is which. A mode bit forces the output low whenever it is clear.

For glitch-free retiming of a live waveform, a second pair of shadow registers holds the next period and compare values. A write to either shadow register only marks the pair as pending. At the last cycle of the period in progress, the pending pair is copied into the active registers, so the new settings start on a clean period boundary. While the output is idle, software can instead write the active registers directly and the change takes hold at once. All registers sit on a simple 32-bit memory-mapped bus with per-byte write enables and a combinational read path.

Top module: `apwm_shadow_timer`

## Requirements
- R1: The active period (byte address 0x08), active compare (0x0C), shadow period (0x10) and shadow compare (0x14) are 32-bit registers. They are written only when the byte address matches exactly, and only on the byte lanes whose enable bit is set. Lane b covers data bits 8b+7..8b. A read returns the stored value.
- R2: The control halfword is reached at byte address 0x2A or 0x28, on byte lanes 2 and 3 (data bits 31:16). It stores only halfword bit 10 (polarity low), bit 9 (PWM enable), bits 7:6 (sync disable, stored only) and bit 4 (counter run). All other bits read as zero.
- R3: Any other address reads as zero, and a write to it changes no register. This includes misaligned byte addresses for the 32-bit registers.
- R4: After reset every register reads zero, the counter is stopped and the output is low.
- R5: The counter advances only while the run bit is set. Clearing the run bit freezes it and the waveform phase with it.
- R6: A period lasts exactly P clock cycles, where P is the active period value. The counter counts 0 to P-1 and then returns to 0. A period of 0 behaves as 1.
- R7: With polarity bit 10 clear and PWM enabled, the output is high while the counter is below the active compare value and low otherwise. A compare value of P or more gives a constant high output.
- R8: With polarity bit 10 set and PWM enabled, the output is the inverse of the R7 level, so the compare count sets the low time.
- R9: While PWM enable (bit 9) is clear, the output is low whatever the polarity, counter and compare values are.
- R10: A shadow write leaves the active registers and the waveform in progress unchanged. Both shadow values are copied into the active registers together on the last cycle of a running period. The copy happens only if a shadow register was written since the previous copy. Without a pending write, the active values are kept.
- R11: A direct write to an active register takes effect from the next clock cycle. If that write lands on the same cycle as a shadow copy, the shadow copy wins.
- R12: A period of 1 with a compare of 1 is legal. It gives a constant high output with normal polarity and a constant low output with inverted polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; period and compare are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_be | input | DATA_W/8 (4) | Per-byte write enables |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the same cycle as the address; zero when no read is selected |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions assume that bus inputs change only between clock edges and that rst_n is held low for more than two clock cycles. The step and wrap properties of the counter also take for granted that software does not shrink the active period below the present count, except where the counter is expected to wrap at once. The stimulus drives every bus transfer on the falling edge for exactly one rising edge and holds reset for five cycles. A behavioural reference model in the bench follows every period shrink. It predicts an immediate wrap whenever the count already exceeds the new period, so the shrink cases are checked against the model rather than left to the assertions.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

  // Byte addresses of the register map
  localparam int unsigned OFS_ACT_PER = 8;
  localparam int unsigned OFS_ACT_CMP = 12;
  localparam int unsigned OFS_SHD_PER = 16;
  localparam int unsigned OFS_SHD_CMP = 20;
  localparam int unsigned OFS_CTRL    = 42;

  // Control halfword bit positions
  localparam int unsigned CB_RUN      = 4;
  localparam int unsigned CB_SYNC_LO  = 6;
  localparam int unsigned CB_SYNC_HI  = 7;
  localparam int unsigned CB_PWM_EN   = 9;
  localparam int unsigned CB_POL_LOW  = 10;

  localparam int unsigned CTRL_W      = 16;
  localparam logic [CTRL_W-1:0] CTRL_KEEP =
    CTRL_W'((1 << CB_RUN) | (1 << CB_SYNC_LO) | (1 << CB_SYNC_HI) |
            (1 << CB_PWM_EN) | (1 << CB_POL_LOW));

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ACT_PER,
    SEL_ACT_CMP,
    SEL_SHD_PER,
    SEL_SHD_CMP,
    SEL_CTRL
  } reg_sel_e;

  typedef struct packed {
    logic pol_low;
    logic pwm_en;
    logic run;
  } apwm_mode_t;

endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                period_end,
  output logic [DATA_W-1:0]   act_per,
  output logic [DATA_W-1:0]   act_cmp,
  output logic [CTRL_W-1:0]   ctrl,
  output logic [DATA_W-1:0]   bus_rdata
);

  localparam int unsigned NB   = DATA_W / 8;
  localparam int unsigned CSH  = DATA_W - CTRL_W;

  reg_sel_e            sel;
  logic [DATA_W-1:0]   lane_mask;
  logic                wr_go;
  logic                xfer;

  logic [DATA_W-1:0]   act_per_q, act_per_d;
  logic [DATA_W-1:0]   act_cmp_q, act_cmp_d;
  logic [DATA_W-1:0]   shd_per_q, shd_per_d;
  logic [DATA_W-1:0]   shd_cmp_q, shd_cmp_d;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic                pend_q, pend_d;
  logic [DATA_W-1:0]   ctrl_word_merged;

  logic                en_act_per, en_act_cmp, en_shd_per, en_shd_cmp;
  logic                en_ctrl, en_pend;

  // Address decode: 32-bit registers need an exact byte address,
  // the control halfword accepts either halfword address of its word.
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_ACT_PER))      sel = SEL_ACT_PER;
    else if (bus_addr == ADDR_W'(OFS_ACT_CMP)) sel = SEL_ACT_CMP;
    else if (bus_addr == ADDR_W'(OFS_SHD_PER)) sel = SEL_SHD_PER;
    else if (bus_addr == ADDR_W'(OFS_SHD_CMP)) sel = SEL_SHD_CMP;
    else if ((bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFS_CTRL >> 2)) && !bus_addr[0])
      sel = SEL_CTRL;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{bus_be[b]}};
  end

  assign wr_go = bus_sel & bus_wr & (|bus_be);
  assign xfer  = period_end & pend_q;

  // Next-state logic
  always_comb begin
    act_per_d = act_per_q;
    act_cmp_d = act_cmp_q;
    shd_per_d = shd_per_q;
    shd_cmp_d = shd_cmp_q;
    ctrl_d    = ctrl_q;
    pend_d    = pend_q & ~xfer;
    ctrl_word_merged = ({ctrl_q, {CSH{1'b0}}} & ~lane_mask) | (bus_wdata & lane_mask);

    if (wr_go) begin
      unique case (sel)
        SEL_ACT_PER: act_per_d = (act_per_q & ~lane_mask) | (bus_wdata & lane_mask);
        SEL_ACT_CMP: act_cmp_d = (act_cmp_q & ~lane_mask) | (bus_wdata & lane_mask);
        SEL_SHD_PER: begin
          shd_per_d = (shd_per_q & ~lane_mask) | (bus_wdata & lane_mask);
          pend_d    = 1'b1;
        end
        SEL_SHD_CMP: begin
          shd_cmp_d = (shd_cmp_q & ~lane_mask) | (bus_wdata & lane_mask);
          pend_d    = 1'b1;
        end
        SEL_CTRL:    ctrl_d = ctrl_word_merged[DATA_W-1:CSH] & CTRL_KEEP;
        default:     ;
      endcase
    end

    // Period-boundary copy takes priority over a direct active write
    if (xfer) begin
      act_per_d = shd_per_q;
      act_cmp_d = shd_cmp_q;
    end
  end

  // Clock enables
  assign en_act_per = xfer | (wr_go & (sel == SEL_ACT_PER));
  assign en_act_cmp = xfer | (wr_go & (sel == SEL_ACT_CMP));
  assign en_shd_per = wr_go & (sel == SEL_SHD_PER);
  assign en_shd_cmp = wr_go & (sel == SEL_SHD_CMP);
  assign en_ctrl    = wr_go & (sel == SEL_CTRL);
  assign en_pend    = xfer | en_shd_per | en_shd_cmp;

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per_q <= '0;
      act_cmp_q <= '0;
      shd_per_q <= '0;
      shd_cmp_q <= '0;
      ctrl_q    <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (en_act_per) act_per_q <= act_per_d;
      if (en_act_cmp) act_cmp_q <= act_cmp_d;
      if (en_shd_per) shd_per_q <= shd_per_d;
      if (en_shd_cmp) shd_cmp_q <= shd_cmp_d;
      if (en_ctrl)    ctrl_q    <= ctrl_d;
      if (en_pend)    pend_q    <= pend_d;
    end
  end

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (sel)
        SEL_ACT_PER: bus_rdata = act_per_q;
        SEL_ACT_CMP: bus_rdata = act_cmp_q;
        SEL_SHD_PER: bus_rdata = shd_per_q;
        SEL_SHD_CMP: bus_rdata = shd_cmp_q;
        SEL_CTRL:    bus_rdata = {ctrl_q, {CSH{1'b0}}};
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign act_per = act_per_q;
  assign act_cmp = act_cmp_q;
  assign ctrl    = ctrl_q;

  // R10: without a copy or a direct write the active period stays put
  a_r10_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !(wr_go && sel == SEL_ACT_PER)) |=> $stable(act_per_q));

  // R10: a copy at the period end loads both shadow values together
  a_r10_copy_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && pend_q) |=>
      (act_per_q == $past(shd_per_q)) && (act_cmp_q == $past(shd_cmp_q)));

  // R10: a shadow write always leaves a copy pending
  a_r10_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (sel == SEL_SHD_PER || sel == SEL_SHD_CMP)) |=> pend_q);

  // R3: a write to an unmapped address leaves the control halfword alone
  a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && sel == SEL_NONE) |=> $stable(ctrl_q));

endmodule

// File: rtl/apwm_timebase.sv
module apwm_timebase #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic              period_end
);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W:0]   cnt_inc;
  logic              last;
  logic              cnt_en;

  // The last count of a period is P-1; a zero period acts as one cycle.
  assign cnt_inc    = {1'b0, cnt_q} + {{DATA_W{1'b0}}, 1'b1};
  assign last       = cnt_inc >= {1'b0, period};
  assign period_end = run & last;
  assign cnt_en     = run;

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      if (last) cnt_d = '0;
      else      cnt_d = cnt_inc[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5: a stopped counter keeps its value
  a_r5_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  // R6: the cycle after a period end starts again at zero
  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt_q == '0));

  // R6: inside a period the counter steps by exactly one
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_end) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/apwm_wave.sv
module apwm_wave
  import apwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] compare,
  input  apwm_mode_t        mode,
  output logic              pwm_out
);

  logic active_phase;
  logic level;

  assign active_phase = count < compare;

  always_comb begin
    level = 1'b0;
    if (mode.pwm_en) begin
      level = mode.pol_low ? ~active_phase : active_phase;
    end
  end

  assign pwm_out = level;

  // R8: with a zero compare the inverted output stays high while enabled
  a_r8_zero_cmp_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.pwm_en && mode.pol_low && compare == '0) |-> pwm_out);

endmodule

// File: rtl/apwm_shadow_timer.sv
module apwm_shadow_timer
  import apwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                pwm_out
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [DATA_W-1:0] act_per;
  logic [DATA_W-1:0] act_cmp;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] count;
  logic              period_end;
  apwm_mode_t        mode;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign mode.pol_low = ctrl[CB_POL_LOW];
  assign mode.pwm_en  = ctrl[CB_PWM_EN];
  assign mode.run     = ctrl[CB_RUN];

  apwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .period_end (period_end),
    .act_per    (act_per),
    .act_cmp    (act_cmp),
    .ctrl       (ctrl),
    .bus_rdata  (bus_rdata)
  );

  apwm_timebase #(.DATA_W(DATA_W)) i_timebase (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run        (mode.run),
    .period     (act_per),
    .count      (count),
    .period_end (period_end)
  );

  apwm_wave #(.DATA_W(DATA_W)) i_wave (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .count   (count),
    .compare (act_cmp),
    .mode    (mode),
    .pwm_out (pwm_out)
  );

  // R9: output held low while PWM mode is off
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    !mode.pwm_en |-> !pwm_out);

  // R7: a period starts high under normal polarity whenever compare is nonzero
  a_r7_period_starts_high: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode.pwm_en && !mode.pol_low && count == '0 && act_cmp != '0) |-> pwm_out);

  // R4: during reset the output stays low
  a_r4_reset_low: assert property (@(posedge clk)
    !rst_core_n |-> !pwm_out);

endmodule

// File: tb/test_apwm_shadow_timer.sv
module test_apwm_shadow_timer;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int    n_checks;
  int    n_errors;
  bit    run_chk;
  string cur_tag;

  // Reference model state
  logic [31:0] m_ap, m_ac, m_sp, m_sc, m_cnt;
  logic [15:0] m_ctrl;
  bit          m_pend;

  apwm_shadow_timer i_apwm_shadow_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] lanes(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    if (a == 6'h08) return m_ap;
    if (a == 6'h0C) return m_ac;
    if (a == 6'h10) return m_sp;
    if (a == 6'h14) return m_sc;
    if (a[5:2] == 4'hA && !a[0]) return {m_ctrl, 16'h0000};
    return 32'h0;
  endfunction

  function automatic bit exp_out();
    bit below;
    below = m_cnt < m_ac;
    if (!m_ctrl[9]) return 1'b0;
    return m_ctrl[10] ? !below : below;
  endfunction

  // Behavioural reference model, stepped on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ap = 0; m_ac = 0; m_sp = 0; m_sc = 0; m_cnt = 0; m_ctrl = 0; m_pend = 0;
    end else begin
      bit          wrap, xfer, we;
      logic [31:0] nap, nac, nsp, nsc;
      logic [15:0] nctrl;
      bit          npend;
      logic [31:0] cw;
      wrap = m_ctrl[4] && ({1'b0, m_cnt} + 33'd1 >= {1'b0, m_ap});
      xfer = wrap && m_pend;
      we   = bus_sel && bus_wr && (bus_be != 0);
      nap = m_ap; nac = m_ac; nsp = m_sp; nsc = m_sc; nctrl = m_ctrl;
      npend = m_pend && !xfer;
      if (we) begin
        if (bus_addr == 6'h08) nap = lanes(m_ap, bus_wdata, bus_be);
        else if (bus_addr == 6'h0C) nac = lanes(m_ac, bus_wdata, bus_be);
        else if (bus_addr == 6'h10) begin nsp = lanes(m_sp, bus_wdata, bus_be); npend = 1; end
        else if (bus_addr == 6'h14) begin nsc = lanes(m_sc, bus_wdata, bus_be); npend = 1; end
        else if (bus_addr[5:2] == 4'hA && !bus_addr[0]) begin
          cw = lanes({m_ctrl, 16'h0}, bus_wdata, bus_be);
          nctrl = cw[31:16] & 16'h06D0;
        end
      end
      if (xfer) begin nap = m_sp; nac = m_sc; end
      if (m_ctrl[4]) m_cnt = wrap ? 32'd0 : m_cnt + 1;
      m_ap = nap; m_ac = nac; m_sp = nsp; m_sc = nsc; m_ctrl = nctrl; m_pend = npend;
    end
  end

  // Output compared against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (run_chk) begin
      n_checks++;
      if (pwm_out !== exp_out()) begin
        n_errors++;
        $display("FAIL %s pwm_out actual %b expected %b at %0t", cur_tag, pwm_out, exp_out(), $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = 0;
    #1;
    chk(tag, bus_rdata, exp_read(a));
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input logic [15:0] hw);
    wr(6'h2A, 4'b1100, {hw, 16'h0000});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0; run_chk = 0; cur_tag = "R4";
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    idle(5);
    rst_n = 1;
    idle(4);
    run_chk = 1;

    // R4: reset values
    chk("R4 pwm_out", {31'h0, pwm_out}, 32'h0);
    rd(6'h08, "R4 act_per"); rd(6'h0C, "R4 act_cmp");
    rd(6'h10, "R4 shd_per"); rd(6'h14, "R4 shd_cmp"); rd(6'h2A, "R4 ctrl");

    // R1: byte lanes and read-back
    cur_tag = "R1";
    wr(6'h08, 4'b0101, 32'h11223344);
    rd(6'h08, "R1 partial lanes");
    chk("R1 partial lanes value", exp_read(6'h08), 32'h00220044);
    wr(6'h0C, 4'b1111, 32'hA5A50F0F); rd(6'h0C, "R1 act_cmp");
    wr(6'h10, 4'b1000, 32'h7F000000); rd(6'h10, "R1 shd_per");
    wr(6'h14, 4'b0011, 32'h0000BEEF); rd(6'h14, "R1 shd_cmp");

    // R2: control halfword masking and both halfword addresses
    cur_tag = "R2";
    ctl(16'hFFFF);
    rd(6'h2A, "R2 ctrl mask");
    chk("R2 ctrl mask value", exp_read(6'h2A), 32'h06D00000);
    rd(6'h28, "R2 ctrl alias");
    wr(6'h28, 4'b0011, 32'hFFFFFFFF);
    rd(6'h2A, "R2 low lanes ignored");
    ctl(16'h0000);

    // R3: unmapped and misaligned addresses
    cur_tag = "R3";
    wr(6'h00, 4'hF, 32'hFFFFFFFF); wr(6'h04, 4'hF, 32'hFFFFFFFF);
    wr(6'h18, 4'hF, 32'hFFFFFFFF); wr(6'h3C, 4'hF, 32'hFFFFFFFF);
    wr(6'h09, 4'hF, 32'hFFFFFFFF); wr(6'h2B, 4'hF, 32'hFFFFFFFF);
    rd(6'h00, "R3 read 0x00"); rd(6'h18, "R3 read 0x18");
    rd(6'h09, "R3 read 0x09"); rd(6'h3C, "R3 read 0x3C");
    rd(6'h08, "R3 act_per unchanged"); rd(6'h2A, "R3 ctrl unchanged");

    // R11: direct writes while idle
    cur_tag = "R11";
    wr(6'h08, 4'hF, 32'd10); wr(6'h0C, 4'hF, 32'd3);
    wr(6'h10, 4'hF, 32'd10); wr(6'h14, 4'hF, 32'd3);
    rd(6'h08, "R11 act_per direct"); rd(6'h0C, "R11 act_cmp direct");

    // R6 and R7: running normal polarity
    cur_tag = "R6/R7 normal waveform";
    ctl(16'h0210);
    idle(35);

    // R5: stop and restart the counter
    cur_tag = "R5 stopped";
    ctl(16'h0200);
    idle(8);
    ctl(16'h0210);
    cur_tag = "R5 restarted";
    idle(12);

    // R8: inverted polarity
    cur_tag = "R8 inverted";
    ctl(16'h0610);
    idle(25);

    // R9: PWM mode off
    cur_tag = "R9 mode off";
    ctl(16'h0410);
    idle(15);
    chk("R9 pwm_out low", {31'h0, pwm_out}, 32'h0);

    // R10: shadow update on period boundary
    cur_tag = "R10 shadow";
    ctl(16'h0210);
    idle(3);
    wr(6'h10, 4'hF, 32'd6); wr(6'h14, 4'hF, 32'd5);
    rd(6'h08, "R10 active unchanged after shadow write");
    rd(6'h0C, "R10 active cmp unchanged");
    idle(20);
    rd(6'h08, "R10 period copied");
    chk("R10 period copied value", exp_read(6'h08), 32'd6);
    rd(6'h0C, "R10 compare copied");

    // R10/R11: no pending shadow write keeps a direct active write
    cur_tag = "R11 direct while running";
    wr(6'h08, 4'hF, 32'd7);
    idle(22);
    rd(6'h08, "R10 no copy without pending");
    chk("R10 no copy value", exp_read(6'h08), 32'd7);

    // R11: shadow copy wins over same-cycle direct write
    cur_tag = "R11 same cycle";
    wr(6'h10, 4'hF, 32'd4); wr(6'h14, 4'hF, 32'd2);
    idle(12);
    rd(6'h08, "R11 after race");

    // R7: compare at or above period is constant high
    cur_tag = "R7 full high";
    wr(6'h0C, 4'hF, 32'd9);
    idle(15);
    chk("R7 constant high", {31'h0, pwm_out}, 32'h1);

    // R12: minimum setting
    cur_tag = "R12 minimum";
    wr(6'h08, 4'hF, 32'd1); wr(6'h0C, 4'hF, 32'd1);
    idle(10);
    chk("R12 high", {31'h0, pwm_out}, 32'h1);
    ctl(16'h0610);
    idle(6);
    chk("R12 inverted low", {31'h0, pwm_out}, 32'h0);

    // R6: zero period behaves as one cycle
    cur_tag = "R6 zero period";
    ctl(16'h0210);
    wr(6'h08, 4'hF, 32'd0); wr(6'h0C, 4'hF, 32'd0);
    idle(6);
    wr(6'h08, 4'hF, 32'd5); wr(6'h0C, 4'hF, 32'd2);
    cur_tag = "R6 short period";
    idle(20);

    run_chk = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule